// File: doc/BRIEF.md
# Phase-Stepping Clock Divider

This block divides a fast input clock by a programmable integer and lets software shift the phase of the divided clock while it runs. A write of a step count to the step register moves the output later by that many input-clock cycles. The block never reloads the counter and never uses a delay line. Instead it lengthens single output periods by one input cycle. Each lengthened period is followed by a fixed number of ordinary periods, so the average output frequency stays close to its nominal value during the adjustment.

A separate half-step control moves the output later by half an input cycle. When half-step is on, the divided clock is retimed on the falling edge of the input clock, so the shift always points later in time. Both output ports come from one divider, one step engine and one half-step stage, so they are always identical.

Configuration uses a small register-write interface with three registers. Address 0 holds the divide value and address 2 holds the half-step enable. Both can be written while the divider is held in reset, and a reset does not clear them. A write to address 1 is the step trigger, and each such write adds its count to the steps still pending.

Top module: `clkdiv_phase_step`

## Requirements
- R1: The output period is N input cycles, where N is the value last written to address 0. Written values of 0 or 1 are treated as 2. The first output rising edge comes on the first input rising edge on which reset is sampled inactive, and N is taken up at each period boundary.
- R2: A write of K to address 1 moves all later output rising edges K input cycles later than those of an unadjusted divider with the same N. Successive writes add. A step write made while reset is low is ignored.
- R3: In every period the output is high for floor(N/2) input cycles. A step is carried out by one period of N+1 cycles, and the extra cycle goes into the low phase.
- R4: At least SPACER ordinary periods (default 3) separate two stretched periods. As a result, only one step is taken per period.
- R5: busy_o rises in the cycle after a nonzero step write and stays high until the last stretched period has ended. A write made while busy_o is high adds its count to the remaining steps.
- R6: When bit 0 of address 2 is 1, the output changes on the falling input edge, half an input cycle later than with the bit at 0. A change of the bit takes effect at the next output transition without a shortened period when enabling.
- R7: clk_out_a_o and clk_out_b_o are identical at all times.
- R8: While rst_ni is low (a synchronous reset, sampled on the clock edge), pending steps are cleared, busy_o is low and both outputs are driven low. After release, the phase is that of an unadjusted divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 divide value, 1 step trigger, 2 half-step enable |
| wr_data_i | input | DATA_W | Write data |
| busy_o | output | 1 | High while steps remain to be taken |
| clk_out_a_o | output | 1 | Divided clock, port A |
| clk_out_b_o | output | 1 | Divided clock, port B (same as A) |

## Verification
Pending-step or spacer state that is wrong shows up at the ports within one adjustment: the output rising edges settle at the wrong offset from a reference divider, or the bench sees stretched periods too close together or counts the wrong number of them. This is visible a few periods after busy_o falls. A wrong period counter or high-phase limit shows in the very next period, either as a wrong rise-to-rise interval or as a wrong high width. A fault in the half-step stage moves the edges by a multiple of 4 ns, or produces a shortened period, within one output period of the write.

// File: rtl/clkdiv_pkg.sv
// Package: shared register selects for the phase-stepping divider.
// Assumes a two-bit register address; unused codes are ignored by the top.
package clkdiv_pkg;
    typedef enum logic [1:0] {
        SEL_DIVIDE = 2'd0,
        SEL_STEP   = 2'd1,
        SEL_HALF   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/clkdiv_counter.sv
// Module: period counter and rising-edge output register.
// Counts 0..N-1 (0..N when stretch_i is set for this period). The output is
// high for the first N/2 counts, so the extra cycle of a stretched period
// falls into the low phase. N is sampled only at period boundaries and is
// loaded straight from div_i while reset is held.
module clkdiv_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             stretch_i,
    output logic             wrap_o,
    output logic             div_o,
    output logic [DIV_W-1:0] n_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] n_q;
    logic [DIV_W-1:0] last_w;
    logic [DIV_W-1:0] high_len_w;
    logic             out_q;

    // Purpose: final count of this period and length of the high phase.
    always_comb begin
        last_w     = stretch_i ? n_q : n_q - DIV_W'(1);
        high_len_w = n_q >> 1;
    end

    assign wrap_o = (cnt_q >= last_w);

    // Purpose: advance the counter, take up N at the boundary, form the output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            n_q   <= div_i;
            out_q <= 1'b0;
        end else begin
            out_q <= (cnt_q < high_len_w);
            if (wrap_o) begin
                cnt_q <= '0;
                n_q   <= div_i;
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end

    assign div_o = out_q;
    assign n_o   = n_q;
endmodule

// File: rtl/clkdiv_step_engine.sv
// Module: step accumulator and stretch scheduler.
// Holds the steps still owed. At each period boundary it either schedules a
// stretched next period (when steps remain and the spacer has expired) or
// counts down the spacer. A write adds to the pending count, saturating.
module clkdiv_step_engine #(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 12,
    parameter int SPACER = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_step_i,
    input  logic [CNT_W-1:0] steps_i,
    input  logic             wrap_i,
    output logic             stretch_o,
    output logic             busy_o
);
    localparam int GAP_W = (SPACER < 1) ? 1 : $clog2(SPACER + 1);

    logic [PEND_W-1:0] pend_q;
    logic [GAP_W-1:0]  gap_q;
    logic              stretch_q;
    logic              take_w;
    logic [PEND_W:0]   sum_w;

    // Purpose: decide whether a step is taken and form the new pending count.
    always_comb begin
        take_w = wrap_i && (pend_q != '0) && (gap_q == '0);
        sum_w  = {1'b0, pend_q} - {{PEND_W{1'b0}}, take_w};
        if (wr_step_i) begin
            sum_w = sum_w + {{(PEND_W + 1 - CNT_W){1'b0}}, steps_i};
        end
    end

    // Purpose: update pending steps, spacer countdown and stretch flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q    <= '0;
            gap_q     <= '0;
            stretch_q <= 1'b0;
        end else begin
            pend_q <= sum_w[PEND_W] ? '1 : sum_w[PEND_W-1:0];
            if (wrap_i) begin
                stretch_q <= take_w;
                if (take_w) begin
                    gap_q <= GAP_W'(SPACER);
                end else if (gap_q != '0) begin
                    gap_q <= gap_q - GAP_W'(1);
                end
            end
        end
    end

    assign stretch_o = stretch_q;
    assign busy_o    = (pend_q != '0) || stretch_q;
endmodule

// File: rtl/clkdiv_halfstep.sv
// Module: optional half-cycle retime of the divided clock.
// A falling-edge flop copies the rising-edge output. The select is taken up
// on a rising edge, where both copies are equal before the edge, so the
// switch cannot glitch; it shows at the next output transition.
module clkdiv_halfstep (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic half_en_i,
    input  logic div_i,
    output logic clk_o
);
    logic fall_q;
    logic sel_q;

    // Purpose: capture the rising-edge output half a cycle later.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= div_i;
        end
    end

    // Purpose: take up the half-step enable on a rising edge.
    always_ff @(posedge clk_i) begin
        sel_q <= half_en_i;
    end

    assign clk_o = sel_q ? fall_q : div_i;
endmodule

// File: rtl/clkdiv_phase_step.sv
// Module: top of the phase-stepping clock divider.
// Decodes register writes, keeps the divide value and half-step enable
// (writable in reset, not cleared by it), and joins the counter, step
// engine and half-step stage. Both output ports share one path.
module clkdiv_phase_step #(
    parameter int DATA_W = 8,
    parameter int PEND_W = DATA_W + 4,
    parameter int SPACER = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              busy_o,
    output logic              clk_out_a_o,
    output logic              clk_out_b_o
);
    import clkdiv_pkg::*;

    localparam logic [DATA_W-1:0] DIV_MIN = DATA_W'(2);

    logic [DATA_W-1:0] div_q;
    logic              half_q;
    logic              wr_step_w;
    logic              wrap_w;
    logic              stretch_q;
    logic              div_out_w;
    logic              clk_w;
    logic [DATA_W-1:0] n_cur;

    assign wr_step_w = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_STEP);

    // Purpose: configuration registers, divide value clamped to its minimum.
    always_ff @(posedge clk_i) begin
        if (wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_DIVIDE)) begin
            div_q <= (wr_data_i < DIV_MIN) ? DIV_MIN : wr_data_i;
        end
        if (wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_HALF)) begin
            half_q <= wr_data_i[0];
        end
    end

    clkdiv_counter #(.DIV_W(DATA_W)) counter_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (div_q),
        .stretch_i (stretch_q),
        .wrap_o    (wrap_w),
        .div_o     (div_out_w),
        .n_o       (n_cur)
    );

    clkdiv_step_engine #(
        .CNT_W  (DATA_W),
        .PEND_W (PEND_W),
        .SPACER (SPACER)
    ) steps_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_step_i (wr_step_w),
        .steps_i   (wr_data_i),
        .wrap_i    (wrap_w),
        .stretch_o (stretch_q),
        .busy_o    (busy_o)
    );

    clkdiv_halfstep half_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .half_en_i (half_q),
        .div_i     (div_out_w),
        .clk_o     (clk_w)
    );

    assign clk_out_a_o = clk_w;
    assign clk_out_b_o = clk_w;
endmodule

// File: rtl/clkdiv_phase_step_chk.sv
// Checker: temporal properties of the phase-stepping divider, bound to the top.
// Assumes the divide register is written before the first reset release.
module clkdiv_phase_step_chk #(
    parameter int DATA_W = 8,
    parameter int SPACER = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              busy_o,
    input logic              clk_out_a_o,
    input logic              wrap_w,
    input logic              stretch_q,
    input logic [DATA_W-1:0] n_cur
);
    logic [7:0] normals_q;
    logic       seen_q;

    // Purpose: count ordinary periods completed since the last stretched one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            normals_q <= '0;
            seen_q    <= 1'b0;
        end else if (wrap_w) begin
            if (stretch_q) begin
                normals_q <= '0;
                seen_q    <= 1'b1;
            end else if (normals_q != 8'hFF) begin
                normals_q <= normals_q + 8'd1;
            end
        end
    end

    p_div_min_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        n_cur >= DATA_W'(2));

    p_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_w && stretch_q && seen_q) |-> (int'(normals_q) >= SPACER));

    p_step_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 2'd1 && wr_data_i != '0) |=> busy_o);

    p_busy_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(wrap_w));

    p_reset_quiet_r8: assert property (@(posedge clk_i)
        !rst_ni |=> (!busy_o && !clk_out_a_o));
endmodule

bind clkdiv_phase_step clkdiv_phase_step_chk #(
    .DATA_W (DATA_W),
    .SPACER (SPACER)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .busy_o      (busy_o),
    .clk_out_a_o (clk_out_a_o),
    .wrap_w      (wrap_w),
    .stretch_q   (stretch_q),
    .n_cur       (n_cur)
);

// File: tb/clkdiv_phase_step_tb.sv
`timescale 1ns/1ps
// Bench: vector table of divide value, step writes and half-step, with the
// expected phase and period, then directed reset and half-step tests.
module clkdiv_phase_step_tb_top;
    localparam int DATA_W = 8;
    localparam int SPACER = 3;
    localparam int TCK    = 8;
    localparam int NVEC   = 8;

    // {N, steps1, steps2, half, phase_ns, period_ns}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd4, 8'd1, 8'd0, 8'd0, 8'd8,  8'd32},
        {8'd5, 8'd2, 8'd1, 8'd0, 8'd24, 8'd40},
        {8'd6, 8'd0, 8'd0, 8'd1, 8'd4,  8'd48},
        {8'd4, 8'd5, 8'd0, 8'd0, 8'd8,  8'd32},
        {8'd7, 8'd3, 8'd2, 8'd1, 8'd44, 8'd56},
        {8'd1, 8'd1, 8'd0, 8'd0, 8'd8,  8'd16},
        {8'd3, 8'd2, 8'd0, 8'd0, 8'd16, 8'd24},
        {8'd8, 8'd4, 8'd4, 8'd1, 8'd4,  8'd64}
    };

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy, out_a, out_b;

    int n_chk = 0, n_fail = 0, ab_miss = 0;
    longint t_ref = 0, last_rise = 0, high_w = 0;
    int rise_n = 0, stretch_n = 0, normals = 0, spc_viol = 0, short_n = 0;
    bit seen = 0;
    int exp_n = 4;

    always #(TCK/2) clk = ~clk;

    clkdiv_phase_step #(.DATA_W(DATA_W), .SPACER(SPACER)) dut_i (
        .clk_i (clk), .rst_ni (rst_ni), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
        .wr_data_i (wr_data), .busy_o (busy), .clk_out_a_o (out_a),
        .clk_out_b_o (out_b)
    );

    // Monitor: rise-to-rise intervals, stretched-period count and spacing.
    always @(posedge out_a) begin
        if (rise_n > 0) begin
            longint iv;
            iv = $time - last_rise;
            if (iv == longint'((exp_n + 1) * TCK)) begin
                if (seen && normals < SPACER) spc_viol++;
                stretch_n++;
                seen = 1;
                normals = 0;
            end else if (iv == longint'(exp_n * TCK)) begin
                normals++;
            end
            if (iv < longint'(exp_n * TCK)) short_n++;
        end
        last_rise = $time;
        rise_n++;
    end

    // Monitor: width of the most recent high phase.
    always @(negedge out_a) begin
        if (rise_n > 0) high_w = $time - last_rise;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        if (out_a !== out_b) ab_miss++;
        #4;
        if (out_a !== out_b) ab_miss++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clear_stats();
        rise_n = 0; stretch_n = 0; normals = 0; spc_viol = 0; short_n = 0; seen = 0;
    endtask

    task automatic release_rst();
        clear_stats();
        rst_ni = 1'b1;
        @(posedge clk);
        t_ref = $time;
        #6;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) tick();
    endtask

    function automatic longint phase(input int per);
        return (last_rise - t_ref) % longint'(per);
    endfunction

    initial begin
        // Reset state (R8)
        rst_ni = 1'b0;
        wr(2'd0, 8'd4);
        wr(2'd2, 8'd0);
        tick(); tick();
        chk(out_a == 1'b0, "R8 output low in reset", out_a, 0);
        chk(busy == 1'b0, "R8 busy low in reset", busy, 0);

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            int n, s1, s2, hs, ph, per;
            {n, s1, s2, hs, ph, per} = {24'd0, VEC[i][47:40], 24'd0, VEC[i][39:32],
                24'd0, VEC[i][31:24], 24'd0, VEC[i][23:16], 24'd0, VEC[i][15:8],
                24'd0, VEC[i][7:0]};
            rst_ni = 1'b0;
            wr(2'd0, DATA_W'(n));
            wr(2'd2, DATA_W'(hs));
            tick();
            exp_n = (n < 2) ? 2 : n;
            release_rst();
            tick(); tick();
            if (s1 != 0) begin
                wr(2'd1, DATA_W'(s1));
                chk(busy == 1'b1, "R5 busy after step write", busy, 1);
            end
            tick(); tick(); tick();
            if (s2 != 0) begin
                chk(busy == 1'b1, "R5 busy before accumulating write", busy, 1);
                wr(2'd1, DATA_W'(s2));
            end
            wait_idle();
            chk(busy == 1'b0, "R5 busy clears when done", busy, 0);
            repeat (3 * exp_n + 2) tick();
            chk(phase(per) == longint'(ph), "R2/R6 phase vs reference", phase(per), ph);
            chk(high_w == longint'((exp_n / 2) * TCK), "R3 high width", high_w, (exp_n / 2) * TCK);
            chk(stretch_n == s1 + s2, "R3 stretched period count", stretch_n, s1 + s2);
            chk(spc_viol == 0, "R4 spacer between stretches", spc_viol, 0);
            chk(short_n == 0, "R1 no short period", short_n, 0);
            begin
                int cur_rise;
                cur_rise = rise_n;
                while (rise_n < cur_rise + 2) tick();
            end
            chk(phase(per) == longint'(ph), "R1 period steady after adjust", phase(per), ph);
        end

        // Reset during an adjustment clears pending steps (R8)
        rst_ni = 1'b0;
        wr(2'd0, 8'd4);
        wr(2'd2, 8'd0);
        exp_n = 4;
        release_rst();
        wr(2'd1, 8'd9);
        repeat (10) tick();
        chk(busy == 1'b1, "R5 busy mid adjustment", busy, 1);
        rst_ni = 1'b0;
        tick();
        chk(busy == 1'b0, "R8 busy cleared by reset", busy, 0);
        chk(out_a == 1'b0, "R8 output low after reset edge", out_a, 0);
        tick();
        release_rst();
        repeat (40) tick();
        chk(busy == 1'b0, "R8 no steps survive reset", busy, 0);
        chk(phase(32) == 0, "R8 phase after reset", phase(32), 0);
        chk(stretch_n == 0, "R8 no stretch after reset", stretch_n, 0);

        // Step write during reset is ignored (R2)
        rst_ni = 1'b0;
        tick();
        wr(2'd1, 8'd3);
        release_rst();
        tick();
        chk(busy == 1'b0, "R2 step write in reset ignored", busy, 0);
        repeat (30) tick();
        chk(phase(32) == 0, "R2 phase unchanged by write in reset", phase(32), 0);

        // Half-step switched at run time (R6)
        rst_ni = 1'b0;
        wr(2'd0, 8'd6);
        exp_n = 6;
        tick();
        release_rst();
        repeat (20) tick();
        wr(2'd2, 8'd1);
        repeat (30) tick();
        chk(phase(48) == 4, "R6 half-step on at run time", phase(48), 4);
        chk(short_n == 0, "R6 no short period on enable", short_n, 0);
        wr(2'd2, 8'd0);
        repeat (30) tick();
        chk(phase(48) == 0, "R6 half-step off at run time", phase(48), 0);

        // Divide value below minimum clamps (R1)
        rst_ni = 1'b0;
        wr(2'd0, 8'd0);
        exp_n = 2;
        tick();
        release_rst();
        repeat (12) tick();
        chk(phase(16) == 0 && short_n == 0, "R1 clamp of zero divide", phase(16), 0);

        chk(ab_miss == 0, "R7 ports identical", ab_miss, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(TCK * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule